// File: doc/BRIEF.md
# Pointer-Indexed Byte Register Port

This block gives a host a narrow, four-location byte port into a 1024-byte internal register space. The host first sets a 10-bit address pointer, which is split across two port locations: one holds the two upper pointer bits and one holds the low eight bits. It then reads or writes the byte the pointer selects through a third location, the data window. The fourth location is a byte path to an external compressed-data FIFO. Its contents are not held here; the block only forwards each written byte with a one-cycle strobe.

The internal space is sparse. Two fixed read-only locations identify the device and its revision. A block of byte RAM that holds marker data fills the top of the space, from 0x060 up to 0x3FF. Every other address reads as zero and ignores writes.

Host reads are combinational. `host_rdata` always reflects the current port select and the current internal state. A write, when `host_en` and `host_we` are both high, takes effect at the next rising clock edge.

Top module: `idxp_top`

## Requirements
- R1: A synchronous active-high reset clears the pointer to 0x000 and deasserts `fifo_push`.
- R2: A write to port 1 loads pointer bits 9:8 from `host_wdata[1:0]` and keeps bits 7:0. A read of port 1 returns the pointer bits 9:8 in bits 1:0, with bits 7:2 zero.
- R3: A write to port 2 loads pointer bits 7:0 from `host_wdata` and keeps bits 9:8. A read of port 2 returns pointer bits 7:0.
- R4: Through port 3, internal address 0x022 reads 0x33 and address 0x023 reads 0x01. Writes to these two addresses leave them unchanged.
- R5: Internal addresses 0x060 to 0x3FF are byte RAM. A write through port 3 is returned by later port 3 reads of the same address.
- R6: Internal addresses below 0x060, other than 0x022 and 0x023, read 0x00 through port 3 and ignore writes.
- R7: Reads and writes through port 3 do not change the pointer, so the pointer never advances on its own.
- R8: Port 0 reads 0x00. A write to port 0 raises `fifo_push` for exactly the following cycle, with `fifo_byte` equal to the written byte. Such a write changes neither the pointer nor the internal space.
- R9: While `host_en` is low, no write takes effect and `fifo_push` stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Access enable |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Port select: 0 FIFO, 1 pointer high, 2 pointer low, 3 data window |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte for the selected port |
| fifo_push | output | 1 | One-cycle strobe for each port 0 write |
| fifo_byte | output | 8 | Byte carried with `fifo_push` |

## Verification
The bench targets the following corner cases:
- Pointer-half merging. A design that cleared the other half on a partial write would misread port 1 or port 2 and miss its data address.
- The RAM edges at 0x05F, 0x060 and 0x3FF. An off-by-one base would either store at 0x05F or lose 0x060, and a wrong offset would alias the top byte.
- Writes aimed at the identification bytes, which must leave them unchanged.
- Repeated data-window accesses, which would expose a stray pointer increment.
- FIFO writes, where a stretched strobe or a pointer update would show up at once.
- Writes issued with the enable low.

A behavioural model of the pointer and the byte space is compared with both outputs on every cycle.

// File: rtl/idxp_pkg.sv
package idxp_pkg;

    localparam int PTR_W  = 10;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        PORT_FIFO   = 2'd0,
        PORT_PTR_HI = 2'd1,
        PORT_PTR_LO = 2'd2,
        PORT_DATA   = 2'd3
    } port_e;

    typedef struct packed {
        logic              wr;
        port_e             port;
        logic [DATA_W-1:0] data;
    } host_op_t;

    localparam logic [PTR_W-1:0]  ADDR_DEVID = 10'h022;
    localparam logic [PTR_W-1:0]  ADDR_REVID = 10'h023;
    localparam logic [PTR_W-1:0]  MARK_BASE  = 10'h060;
    localparam logic [DATA_W-1:0] DEVID_VAL  = 8'h33;
    localparam logic [DATA_W-1:0] REVID_VAL  = 8'h01;

    function automatic logic in_marker(logic [PTR_W-1:0] a);
        return a >= MARK_BASE;
    endfunction

endpackage

// File: rtl/idxp_pointer.sv
module idxp_pointer
    import idxp_pkg::*;
#(
    parameter int AW = PTR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  host_op_t      op,
    output logic [AW-1:0] ptr
);
    localparam int HI_W = AW - DW;

    logic hi_wr, lo_wr;

    always_comb begin
        hi_wr = op.wr && (op.port == PORT_PTR_HI);
        lo_wr = op.wr && (op.port == PORT_PTR_LO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            if (hi_wr) ptr[AW-1:DW] <= op.data[HI_W-1:0];
            if (lo_wr) ptr[DW-1:0]  <= op.data;
        end
    end

    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> ptr[DW-1:0] == $past(ptr[DW-1:0])); // R2
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> ptr[AW-1:DW] == $past(ptr[AW-1:DW])); // R3
    AST_PTR_NO_DRIFT: assert property (@(posedge clk) disable iff (rst)
        !(hi_wr || lo_wr) |=> $stable(ptr)); // R7

endmodule

// File: rtl/idxp_space.sv
module idxp_space
    import idxp_pkg::*;
#(
    parameter int AW = PTR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int SPACE = 1 << AW;
    localparam int MARK_DEPTH = SPACE - int'(MARK_BASE);

    logic [DW-1:0] mark_mem [MARK_DEPTH];
    logic          hit_mark;
    logic [AW-1:0] mark_idx;

    always_comb begin
        hit_mark = in_marker(addr);
        mark_idx = addr - MARK_BASE;
    end

    always_ff @(posedge clk) begin
        if (!rst && we && hit_mark) begin
            mark_mem[mark_idx] <= wdata;
        end
    end

    always_comb begin
        if (hit_mark)                rdata = mark_mem[mark_idx];
        else if (addr == ADDR_DEVID) rdata = DEVID_VAL;
        else if (addr == ADDR_REVID) rdata = REVID_VAL;
        else                         rdata = '0;
    end

    AST_MARK_RETAINS: assert property (@(posedge clk) disable iff (rst)
        (we && hit_mark) |=> (addr != $past(addr)) || (rdata == $past(wdata))); // R5

endmodule

// File: rtl/idxp_top.sv
module idxp_top
    import idxp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_en,
    input  logic       host_we,
    input  logic [1:0] host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       fifo_push,
    output logic [7:0] fifo_byte
);
    host_op_t      op;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] space_rdata;
    logic          fifo_wr;
    logic          data_wr;

    always_comb begin
        op.wr   = host_en && host_we;
        op.port = port_e'(host_sel);
        op.data = host_wdata;
        fifo_wr = op.wr && (op.port == PORT_FIFO);
        data_wr = op.wr && (op.port == PORT_DATA);
    end

    idxp_pointer #(.AW(PTR_W), .DW(DATA_W)) u_ptr (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .ptr (ptr)
    );

    idxp_space #(.AW(PTR_W), .DW(DATA_W)) u_space (
        .clk   (clk),
        .rst   (rst),
        .addr  (ptr),
        .we    (data_wr),
        .wdata (host_wdata),
        .rdata (space_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_push <= 1'b0;
            fifo_byte <= '0;
        end else begin
            fifo_push <= fifo_wr;
            if (fifo_wr) fifo_byte <= host_wdata;
        end
    end

    always_comb begin
        unique case (op.port)
            PORT_FIFO:   host_rdata = '0;
            PORT_PTR_HI: host_rdata = {{(2*DATA_W-PTR_W){1'b0}}, ptr[PTR_W-1:DATA_W]};
            PORT_PTR_LO: host_rdata = ptr[DATA_W-1:0];
            default:     host_rdata = space_rdata;
        endcase
    end

    AST_FIFO_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> $past(fifo_wr) && (fifo_byte == $past(host_wdata))); // R8
    AST_IDLE_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        !host_en |=> !fifo_push); // R9

endmodule

// File: tb/idxp_top_test.sv
`timescale 1ns/1ps
module idxp_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_en = 1'b0;
    logic       host_we = 1'b0;
    logic [1:0] host_sel = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       fifo_push;
    logic [7:0] fifo_byte;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    idxp_top uut (
        .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fifo_push(fifo_push), .fifo_byte(fifo_byte)
    );

    // behavioural reference state
    logic [9:0] m_ptr = '0;
    logic [7:0] m_mem [1024];
    bit         m_known [1024];
    bit         m_push = 1'b0;
    logic [7:0] m_byte = '0;

    initial begin
        for (int i = 0; i < 1024; i++) m_known[i] = 1'b0;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_ptr  <= '0;
            m_push <= 1'b0;
        end else begin
            m_push <= host_en && host_we && host_sel == 2'd0;
            if (host_en && host_we) begin
                case (host_sel)
                    2'd0: m_byte <= host_wdata;
                    2'd1: m_ptr[9:8] <= host_wdata[1:0];
                    2'd2: m_ptr[7:0] <= host_wdata;
                    default: if (m_ptr >= 10'h060) begin
                        m_mem[m_ptr]   <= host_wdata;
                        m_known[m_ptr] <= 1'b1;
                    end
                endcase
            end
        end
    end

    function automatic string tag_of(logic [1:0] s, logic [9:0] p);
        if (s == 2'd0) return "R8";
        if (s == 2'd1) return "R2";
        if (s == 2'd2) return "R3";
        if (p == 10'h022 || p == 10'h023) return "R4";
        if (p >= 10'h060) return "R5";
        return "R6";
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [7:0] exp_rd;
            bit         valid;
            valid = 1'b1;
            case (host_sel)
                2'd0: exp_rd = 8'h00;
                2'd1: exp_rd = {6'b0, m_ptr[9:8]};
                2'd2: exp_rd = m_ptr[7:0];
                default: begin
                    if (m_ptr == 10'h022)      exp_rd = 8'h33;
                    else if (m_ptr == 10'h023) exp_rd = 8'h01;
                    else if (m_ptr >= 10'h060) begin
                        exp_rd = m_mem[m_ptr];
                        valid  = m_known[m_ptr];
                    end else exp_rd = 8'h00;
                end
            endcase
            if (valid) begin
                n_checks++;
                if (host_rdata !== exp_rd) begin
                    n_fail++;
                    $display("FAIL %s rdata sel=%0d ptr=%h actual=%h expected=%h",
                             tag_of(host_sel, m_ptr), host_sel, m_ptr, host_rdata, exp_rd);
                end
            end
            n_checks++;
            if (fifo_push !== m_push || (m_push && fifo_byte !== m_byte)) begin
                n_fail++;
                $display("FAIL R8/R9 fifo actual=%b/%h expected=%b/%h",
                         fifo_push, fifo_byte, m_push, m_byte);
            end
        end
    end

    task automatic drive(input bit en, input bit we, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        #1;
        host_en = en; host_we = we; host_sel = s; host_wdata = d;
    endtask

    task automatic set_ptr(input logic [9:0] p);
        drive(1, 1, 2'd1, {6'b0, p[9:8]});
        drive(1, 1, 2'd2, p[7:0]);
    endtask

    task automatic check_now(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    initial begin
        #100000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        drive(1, 0, 2'd2, 8'h00);
        @(negedge clk);
        check_now("R1 ptr low", host_rdata, 8'h00);
        check_now("R1 fifo_push", {7'b0, fifo_push}, 8'h00);
        drive(1, 0, 2'd1, 8'h00);
        @(negedge clk);
        check_now("R1 ptr high", host_rdata, 8'h00);
        // R2/R3 partial pointer writes
        set_ptr(10'h234);
        drive(1, 1, 2'd3, 8'hA5);            // R5 write
        repeat (3) drive(1, 0, 2'd3, 8'h00); // R7 repeated reads
        drive(1, 0, 2'd2, 8'h00);
        @(negedge clk);
        check_now("R7 ptr low after data accesses", host_rdata, 8'h34);
        drive(1, 1, 2'd1, 8'hFF);            // R2 only bits 1:0 count
        drive(1, 0, 2'd1, 8'h00);
        @(negedge clk);
        check_now("R2 high readback", host_rdata, 8'h03);
        drive(1, 0, 2'd2, 8'h00);
        @(negedge clk);
        check_now("R2 low kept", host_rdata, 8'h34);
        // R4 identification bytes
        set_ptr(10'h022);
        drive(1, 1, 2'd3, 8'h77);
        drive(1, 0, 2'd3, 8'h00);
        @(negedge clk);
        check_now("R4 device id", host_rdata, 8'h33);
        set_ptr(10'h023);
        drive(1, 1, 2'd3, 8'hEE);
        drive(1, 0, 2'd3, 8'h00);
        @(negedge clk);
        check_now("R4 revision", host_rdata, 8'h01);
        // R6 unmapped, boundary 0x05F
        set_ptr(10'h05F);
        drive(1, 1, 2'd3, 8'h5A);
        drive(1, 0, 2'd3, 8'h00);
        @(negedge clk);
        check_now("R6 0x05F", host_rdata, 8'h00);
        // R5 RAM edges
        set_ptr(10'h060);
        drive(1, 1, 2'd3, 8'hC3);
        drive(1, 0, 2'd3, 8'h00);
        @(negedge clk);
        check_now("R5 0x060", host_rdata, 8'hC3);
        set_ptr(10'h3FF);
        drive(1, 1, 2'd3, 8'h3C);
        drive(1, 0, 2'd3, 8'h00);
        @(negedge clk);
        check_now("R5 0x3FF", host_rdata, 8'h3C);
        // R8 fifo strobe
        drive(1, 1, 2'd0, 8'h5C);
        drive(1, 0, 2'd0, 8'h00);
        check_now("R8 push", {7'b0, fifo_push}, 8'h01);
        check_now("R8 byte", fifo_byte, 8'h5C);
        @(negedge clk);
        check_now("R8 single cycle", {7'b0, fifo_push}, 8'h00);
        check_now("R8 port0 read", host_rdata, 8'h00);
        // R9 disabled writes
        drive(0, 1, 2'd2, 8'h11);
        drive(0, 1, 2'd0, 8'h22);
        drive(1, 0, 2'd2, 8'h00);
        check_now("R9 no push", {7'b0, fifo_push}, 8'h00);
        @(negedge clk);
        check_now("R9 ptr low unchanged", host_rdata, 8'hFF);
        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[1], lfsr[2], lfsr[4:3], lfsr[15:8]);
        end
        drive(0, 0, 2'd0, 8'h00);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule